// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

When the processor core has accepted an interrupt, this block builds the exception frame on the system stack and switches the level mask. It takes a single start pulse together with the accepted request's level and number, the address of the interrupted instruction, a two-bit length class for that instruction, the current status word and the current system stack pointer. It captures all of these in the start cycle.

From the captured values it forms the resume address. It then drives a 32-bit write port through two pushes. The first push moves the stack pointer down one word and writes the status word. The second push moves it down again and writes the resume address. After the pushes it loads the level mask with the request's level, publishes the handler's vector-table slot and pulses done.

The sequencer takes one frame at a time. A start that arrives while a frame is being built is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: With length class 2'b10 (32-bit immediate load), the resume address written to the stack is the captured instruction address plus 6, modulo 2^32.
- R2: With length class 2'b01 (20-bit immediate load or coprocessor operate, load, store or save), the resume address is the instruction address plus 4.
- R3: With length class 2'b00 or 2'b11 (all other instructions), the resume address is the instruction address plus 2.
- R4: In the cycle after start, the stack pointer output falls by 4. In the following cycle the write port asserts enable, uses byte strobe 4'hF, takes the new stack pointer as address and carries the captured status word.
- R5: In the next cycle the stack pointer falls by 4 again. The cycle after that carries a second write of the resume address at this new stack pointer.
- R6: Two cycles after the second write, the level-mask output takes the captured level. It changes at no other time, and its reset value is all ones.
- R7: In the same cycle as R6, the vector output becomes VEC_BASE + 4*(2^NUM_W-1 - number), modulo 2^32. Its reset value is 0.
- R8: busy is high from the cycle after start through the done cycle. Done is a single-cycle pulse in the cycle in which the new mask and vector first appear. The write enable is never high outside busy.
- R9: A start that arrives while busy is ignored: the frame, the mask and the vector follow the first request only.
- R10: The stack pointer wraps modulo 2^32. A captured pointer of 4 produces writes at 0 and then at 0xFFFFFFFC.
- R11: After reset, busy, done and the write enable are 0, and the stack pointer and vector outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accepted-interrupt pulse; ignored while busy |
| level_i | input | LVL_W | Level of the accepted request |
| irq_num_i | input | NUM_W | Number of the accepted request |
| pc_i | input | AW | Address of the interrupted instruction |
| iclass_i | input | 2 | Instruction length class |
| status_i | input | DW | Status word to push |
| ssp_i | input | AW | System stack pointer at entry |
| busy_o | output | 1 | Frame being built |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | AW | Current system stack pointer |
| ilm_o | output | LVL_W | Level mask |
| vec_addr_o | output | AW | Vector-table slot of the handler |
| mem_we_o | output | 1 | Stack write enable |
| mem_be_o | output | DW/8 | Byte strobes |
| mem_addr_o | output | AW | Stack write address |
| mem_wdata_o | output | DW | Stack write data |

## Verification
Each captured value appears at the ports within six cycles of start. A wrong state-register value therefore shows as a write in the wrong cycle, a missing or doubled done, or a stack-pointer step in the wrong place, and the per-clock model comparison catches it on that same edge. A corrupted captured field (level, number, resume address or status) shows on the write-data, mask or vector outputs no later than the done cycle of that frame. Starts issued mid-frame expose any leak of the new request into the frame under way.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DEC_PS = 3'd1,
        ST_WR_PS  = 3'd2,
        ST_DEC_RA = 3'd3,
        ST_WR_RA  = 3'd4,
        ST_MASK   = 3'd5,
        ST_FIN    = 3'd6
    } seq_state_e;

    localparam logic [1:0] CLS_SHORT = 2'b00;
    localparam logic [1:0] CLS_MED   = 2'b01;
    localparam logic [1:0] CLS_LONG  = 2'b10;
    localparam logic [1:0] CLS_OTHER = 2'b11;

endpackage

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc_i,
    input  logic [1:0]    iclass_i,
    output logic [AW-1:0] ret_o
);
    import exc_pkg::*;

    logic [3:0] step;

    always_comb begin
        unique case (iclass_i)
            CLS_LONG: step = 4'd6;
            CLS_MED:  step = 4'd4;
            default:  step = 4'd2;
        endcase
        ret_o = pc_i + AW'(step);
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
    parameter int          AW       = 32,
    parameter int          NUM_W    = 8,
    parameter logic [31:0] VEC_BASE = 32'h000F_FC00
) (
    input  logic [NUM_W-1:0] num_i,
    output logic [AW-1:0]    vec_o
);
    localparam logic [NUM_W-1:0] TOP_NUM = {NUM_W{1'b1}};

    logic [NUM_W-1:0] slot;

    always_comb begin
        slot  = TOP_NUM - num_i;
        vec_o = AW'(VEC_BASE) + (AW'(slot) << 2);
    end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LVL_W = 5,
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [NUM_W-1:0] irq_num_i,
    input  logic [AW-1:0]    ret_i,
    input  logic [DW-1:0]    status_i,
    input  logic [AW-1:0]    ssp_i,
    input  logic [AW-1:0]    vec_i,
    output logic [NUM_W-1:0] num_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    sp_o,
    output logic [LVL_W-1:0] ilm_o,
    output logic [AW-1:0]    vec_addr_o,
    output logic             mem_we_o,
    output logic [DW/8-1:0]  mem_be_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o
);
    import exc_pkg::*;

    localparam int          BE_W     = DW / 8;
    localparam logic [AW-1:0] WORD   = AW'(4);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    sp;
        logic [DW-1:0]    ps;
        logic [AW-1:0]    ra;
        logic [LVL_W-1:0] lvl;
        logic [NUM_W-1:0] num;
        logic [LVL_W-1:0] ilm;
        logic [AW-1:0]    vec;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_DEC_PS;
                    r_d.sp  = ssp_i;
                    r_d.ps  = status_i;
                    r_d.ra  = ret_i;
                    r_d.lvl = level_i;
                    r_d.num = irq_num_i;
                end
            end
            ST_DEC_PS: begin
                r_d.sp = r_q.sp - WORD;
                r_d.st = ST_WR_PS;
            end
            ST_WR_PS:  r_d.st = ST_DEC_RA;
            ST_DEC_RA: begin
                r_d.sp = r_q.sp - WORD;
                r_d.st = ST_WR_RA;
            end
            ST_WR_RA:  r_d.st = ST_MASK;
            ST_MASK: begin
                r_d.ilm = r_q.lvl;
                r_d.vec = vec_i;
                r_d.st  = ST_FIN;
            end
            ST_FIN:    r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.sp  <= '0;
            r_q.ps  <= '0;
            r_q.ra  <= '0;
            r_q.lvl <= '0;
            r_q.num <= '0;
            r_q.ilm <= '1;
            r_q.vec <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic wr_ps, wr_ra;

    always_comb begin
        wr_ps       = (r_q.st == ST_WR_PS);
        wr_ra       = (r_q.st == ST_WR_RA);
        mem_we_o    = wr_ps | wr_ra;
        mem_be_o    = mem_we_o ? {BE_W{1'b1}} : '0;
        mem_addr_o  = r_q.sp;
        mem_wdata_o = wr_ra ? DW'(r_q.ra) : r_q.ps;
        busy_o      = (r_q.st != ST_IDLE);
        done_o      = (r_q.st == ST_FIN);
        sp_o        = r_q.sp;
        ilm_o       = r_q.ilm;
        vec_addr_o  = r_q.vec;
        num_o       = r_q.num;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
    parameter int          AW       = 32,
    parameter int          DW       = 32,
    parameter int          LVL_W    = 5,
    parameter int          NUM_W    = 8,
    parameter logic [31:0] VEC_BASE = 32'h000F_FC00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [NUM_W-1:0] irq_num_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [1:0]       iclass_i,
    input  logic [DW-1:0]    status_i,
    input  logic [AW-1:0]    ssp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [AW-1:0]    sp_o,
    output logic [LVL_W-1:0] ilm_o,
    output logic [AW-1:0]    vec_addr_o,
    output logic             mem_we_o,
    output logic [DW/8-1:0]  mem_be_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o
);
    logic [AW-1:0]    ret_w;
    logic [AW-1:0]    vec_w;
    logic [NUM_W-1:0] num_w;

    exc_ret_addr #(.AW(AW)) u_ret (
        .pc_i     (pc_i),
        .iclass_i (iclass_i),
        .ret_o    (ret_w)
    );

    exc_vec_addr #(.AW(AW), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE)) u_vec (
        .num_i (num_w),
        .vec_o (vec_w)
    );

    exc_seq_ctrl #(.AW(AW), .DW(DW), .LVL_W(LVL_W), .NUM_W(NUM_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .level_i     (level_i),
        .irq_num_i   (irq_num_i),
        .ret_i       (ret_w),
        .status_i    (status_i),
        .ssp_i       (ssp_i),
        .vec_i       (vec_w),
        .num_o       (num_w),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .sp_o        (sp_o),
        .ilm_o       (ilm_o),
        .vec_addr_o  (vec_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_be_o    (mem_be_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic [AW-1:0]    sp_o,
    input logic [LVL_W-1:0] ilm_o,
    input logic             mem_we_o,
    input logic [DW/8-1:0]  mem_be_o,
    input logic [AW-1:0]    mem_addr_o
);
    p_wr_at_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == sp_o) && (mem_be_o == '1));

    p_wr_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    p_sp_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (sp_o != $past(sp_o))) |-> (sp_o == $past(sp_o) - AW'(4)));

    p_ilm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(ilm_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_we_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.AW(AW), .DW(DW), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sp_o       (sp_o),
    .ilm_o      (ilm_o),
    .mem_we_o   (mem_we_o),
    .mem_be_o   (mem_be_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam logic [31:0] BASE = 32'h000F_FC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  level_i = '0;
    logic [7:0]  irq_num_i = '0;
    logic [31:0] pc_i = '0;
    logic [1:0]  iclass_i = '0;
    logic [31:0] status_i = '0;
    logic [31:0] ssp_i = '0;
    logic        busy_o, done_o, mem_we_o;
    logic [31:0] sp_o, vec_addr_o, mem_addr_o, mem_wdata_o;
    logic [4:0]  ilm_o;
    logic [3:0]  mem_be_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .level_i(level_i),
        .irq_num_i(irq_num_i), .pc_i(pc_i), .iclass_i(iclass_i),
        .status_i(status_i), .ssp_i(ssp_i), .busy_o(busy_o), .done_o(done_o),
        .sp_o(sp_o), .ilm_o(ilm_o), .vec_addr_o(vec_addr_o),
        .mem_we_o(mem_we_o), .mem_be_o(mem_be_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    // behavioural reference: phase 0 idle, 1..6 = steps of one frame
    int          m_phase = 0;
    logic [31:0] m_sp = 0, m_ps = 0, m_ra = 0, m_vec = 0;
    logic [4:0]  m_lvl = 0, m_ilm = 5'h1F;
    logic [7:0]  m_num = 0;
    logic [1:0]  m_cls = 0;

    function automatic logic [31:0] ret_of(logic [31:0] pc, logic [1:0] c);
        if (c == 2'b10) return pc + 32'd6;
        if (c == 2'b01) return pc + 32'd4;
        return pc + 32'd2;
    endfunction

    function automatic string ra_tag(logic [1:0] c);
        if (c == 2'b10) return "R1";
        if (c == 2'b01) return "R2";
        return "R3";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_sp <= 0; m_ilm <= 5'h1F; m_vec <= 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_phase <= 1; m_sp <= ssp_i; m_ps <= status_i;
                    m_ra <= ret_of(pc_i, iclass_i); m_cls <= iclass_i;
                    m_lvl <= level_i; m_num <= irq_num_i;
                end
                1: begin m_sp <= m_sp - 32'd4; m_phase <= 2; end
                3: begin m_sp <= m_sp - 32'd4; m_phase <= 4; end
                5: begin
                    m_ilm <= m_lvl;
                    m_vec <= BASE + 32'd4 * (32'd255 - {24'd0, m_num});
                    m_phase <= 6;
                end
                6: m_phase <= 0;
                default: m_phase <= m_phase + 1;
            endcase
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            string wt;
            wt = (m_phase == 4) ? "R5" : "R4";
            check("R8", "busy", {31'd0, busy_o}, {31'd0, m_phase != 0});
            check("R8", "done", {31'd0, done_o}, {31'd0, m_phase == 6});
            check(wt, "we", {31'd0, mem_we_o}, {31'd0, (m_phase == 2) || (m_phase == 4)});
            check(wt, "sp", sp_o, m_sp);
            check("R6", "ilm", {27'd0, ilm_o}, {27'd0, m_ilm});
            check("R7", "vec", vec_addr_o, m_vec);
            if (m_phase == 2 || m_phase == 4) begin
                check(wt, "addr", mem_addr_o, m_sp);
                check(wt, "be", {28'd0, mem_be_o}, 32'hF);
                check((m_phase == 4) ? ra_tag(m_cls) : "R4", "wdata",
                      mem_wdata_o, (m_phase == 4) ? m_ra : m_ps);
            end
        end
    end

    task automatic frame(logic [4:0] lv, logic [7:0] nm, logic [31:0] pc,
                         logic [1:0] cl, logic [31:0] ps, logic [31:0] sp);
        @(negedge clk);
        start_i = 1'b1; level_i = lv; irq_num_i = nm; pc_i = pc;
        iclass_i = cl; status_i = ps; ssp_i = sp;
        @(negedge clk);
        start_i = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "busy rst", {31'd0, busy_o}, 32'd0);
        check("R11", "done rst", {31'd0, done_o}, 32'd0);
        check("R11", "we rst", {31'd0, mem_we_o}, 32'd0);
        check("R11", "sp rst", sp_o, 32'd0);
        check("R11", "vec rst", vec_addr_o, 32'd0);
        check("R6", "ilm rst", {27'd0, ilm_o}, 32'h1F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        frame(5'd3,  8'd17,  32'h0000_1000, 2'b10, 32'hA5A5_0001, 32'h0002_0000); // R1
        frame(5'd7,  8'd0,   32'h0000_2002, 2'b01, 32'h1234_5678, 32'h0002_0000); // R2
        frame(5'd12, 8'd255, 32'h0000_3004, 2'b00, 32'hDEAD_BEEF, 32'h0001_FFF8); // R3
        frame(5'd30, 8'd128, 32'hFFFF_FFFE, 2'b11, 32'h0BAD_F00D, 32'h0000_8000); // R3 wrap
        frame(5'd1,  8'd64,  32'hFFFF_FFFC, 2'b10, 32'h0000_0001, 32'h0000_0004); // R10

        // R10 explicit: pointer wrapped below zero
        check("R10", "sp wrap", sp_o, 32'hFFFF_FFFC);

        // R9: start pulses during a busy frame are dropped
        @(negedge clk);
        start_i = 1'b1; level_i = 5'd9; irq_num_i = 8'd5; pc_i = 32'h100;
        iclass_i = 2'b01; status_i = 32'h1111_1111; ssp_i = 32'h4000;
        @(negedge clk);
        level_i = 5'd20; irq_num_i = 8'd99; status_i = 32'h2222_2222; ssp_i = 32'h9000;
        repeat (4) @(negedge clk);
        start_i = 1'b0;
        repeat (8) @(negedge clk);
        check("R9", "ilm first req", {27'd0, ilm_o}, 32'd9);
        check("R9", "vec first req", vec_addr_o, BASE + 32'd4 * 32'd250);
        check("R9", "sp first req", sp_o, 32'h4000 - 32'd8);

        // back-to-back frames: start held high across the done cycle
        @(negedge clk);
        start_i = 1'b1; level_i = 5'd2; irq_num_i = 8'd1; pc_i = 32'h500;
        iclass_i = 2'b00; status_i = 32'h3333_3333; ssp_i = 32'h6000;
        repeat (14) @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule